// File: doc/BRIEF.md
# AXI Write Privilege Firewall

This block sits on an AXI link between one initiator and a group of target regions, and it checks the privilege of every write. The write address goes to one of N regions. Each region is set by a base and mask pair, and when several regions match, the lowest index wins. Each region holds a privilege state. A region marked programmable takes that state from a small configuration register port. Any other region is locked to its build-time value. A write passes when its privilege bit is set or when its region is non-privileged. A write whose privilege bit is clear and whose region is privileged is stopped at the firewall. Reads pass straight through and are never checked.

A stopped write never reaches the target. The firewall takes the address, accepts every data beat up to the last one, and returns a single error response carrying the write's ID. It handles one write at a time. New addresses are refused while a write's data is moving or while an error response is waiting. A sticky flag and an address register record the first stopped write so that software can inspect it. Software clears the flag by writing 1 to it. A write that matches no region is sent on unchecked, so the target still reports its own decode errors.

Top module: `priv_write_guard`

## Requirements
- R1: The read address and read data channels pass through unchanged, whatever the privilege bit or the region's state: every AR and R field, and both valid/ready pairs, are copied across.
- R2: A write with privilege bit 1 (bit 0 of the write protection field) to a privileged region is forwarded. The target sees the same address, ID and protection field, and every data beat in order with its last flag. The target's OKAY (00) response comes back with its ID.
- R3: A write with privilege bit 0 to a non-privileged region, or with privilege bit 1 to any region, is forwarded exactly as in R2.
- R4: A write with privilege bit 0 to a privileged region never raises address valid or data valid toward the target. All of its data beats are accepted up to the last flag. It gets exactly one write response of SLVERR (10) carrying its own ID.
- R5: A write whose address matches no region is forwarded unchecked. With the default map this means any address at 0x4000_0000 or above. Regions 0 to 3 cover address bits [31:28] = 0 to 3.
- R6: After reset, configuration register 0 reads the build-time privilege vector, with bit i set meaning region i is privileged. The default is 0101: regions 0 and 2 privileged, regions 1 and 3 not. The status flag reads 0.
- R7: A write to configuration register 0 updates the privilege bit of each programmable region (regions 0 and 1 by default). The new state applies to the next write decision.
- R8: A write to configuration register 0 leaves the bit of a fixed region (regions 2 and 3 by default) unchanged, both in read-back and in the write decision.
- R9: Configuration register 1 bit 0 is a sticky flag that is set by a stopped write. Configuration register 2 holds the address of the first stopped write since the flag was last clear. Later stopped writes change neither. Writing 1 to register 1 bit 0 clears the flag.
- R10: After a stopped write's address is accepted, the upstream address ready stays low until its error response has completed its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAwValid | input | 1 | Upstream write address valid |
| sAwReady | output | 1 | Upstream write address ready |
| sAwId | input | ID_W | Upstream write ID |
| sAwAddr | input | ADDR_W | Upstream write address |
| sAwProt | input | 3 | Upstream write protection, bit 0 = privileged |
| sWValid | input | 1 | Upstream write data valid |
| sWReady | output | 1 | Upstream write data ready |
| sWData | input | DATA_W | Upstream write data |
| sWStrb | input | DATA_W/8 | Upstream write strobes |
| sWLast | input | 1 | Upstream last beat |
| sBValid | output | 1 | Upstream write response valid |
| sBReady | input | 1 | Upstream write response ready |
| sBId | output | ID_W | Upstream response ID |
| sBResp | output | 2 | Upstream response code |
| sArValid | input | 1 | Upstream read address valid |
| sArReady | output | 1 | Upstream read address ready |
| sArId | input | ID_W | Upstream read ID |
| sArAddr | input | ADDR_W | Upstream read address |
| sArProt | input | 3 | Upstream read protection |
| sRValid | output | 1 | Upstream read data valid |
| sRReady | input | 1 | Upstream read data ready |
| sRId | output | ID_W | Upstream read ID |
| sRData | output | DATA_W | Upstream read data |
| sRResp | output | 2 | Upstream read response |
| sRLast | output | 1 | Upstream read last |
| mAwValid | output | 1 | Target write address valid |
| mAwReady | input | 1 | Target write address ready |
| mAwId | output | ID_W | Target write ID |
| mAwAddr | output | ADDR_W | Target write address |
| mAwProt | output | 3 | Target write protection |
| mWValid | output | 1 | Target write data valid |
| mWReady | input | 1 | Target write data ready |
| mWData | output | DATA_W | Target write data |
| mWStrb | output | DATA_W/8 | Target write strobes |
| mWLast | output | 1 | Target last beat |
| mBValid | input | 1 | Target write response valid |
| mBReady | output | 1 | Target write response ready |
| mBId | input | ID_W | Target response ID |
| mBResp | input | 2 | Target response code |
| mArValid | output | 1 | Target read address valid |
| mArReady | input | 1 | Target read address ready |
| mArId | output | ID_W | Target read ID |
| mArAddr | output | ADDR_W | Target read address |
| mArProt | output | 3 | Target read protection |
| mRValid | input | 1 | Target read data valid |
| mRReady | output | 1 | Target read data ready |
| mRId | input | ID_W | Target read ID |
| mRData | input | DATA_W | Target read data |
| mRResp | input | 2 | Target read response |
| mRLast | input | 1 | Target read last |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 2 | Configuration write register select |
| cfgWrData | input | N_REGION | Configuration write data |
| cfgRdAddr | input | 2 | Configuration read register select |
| cfgRdData | output | ADDR_W | Configuration read data |

## Verification
The hardest state to reach is a stopped write that is still draining or still waiting on its response while the sticky flag already holds an earlier address. Only then do R9's first-event capture and R10's refusal of new addresses both matter. The stimulus sends directed back-to-back stopped writes to two different privileged regions before any clear. Random bursts then mix in reprogrammed privilege vectors and random ready and response-ready throttling, so that draining and response waits stretch over several cycles. Each write's expected outcome comes from a bench model of the privilege vector and the flag.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {IDLE_S, FWD_S, DRAIN_S, RESP_S} wrState_e;

  // strobes from the write control to the region datapath
  typedef struct packed {
    logic captureBlk;   // a blocked write address is being accepted this cycle
  } ctrlStrobes_t;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [1:0] CFG_REG_PRIV = 2'd0;
  localparam logic [1:0] CFG_REG_STAT = 2'd1;
  localparam logic [1:0] CFG_REG_ADDR = 2'd2;
endpackage

// File: rtl/pwg_region_path.sv
module pwg_region_path
  import pwg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W = 4,
  parameter int N_REGION = 4,
  parameter logic [N_REGION*ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [N_REGION*ADDR_W-1:0] REGION_MASK = '0,
  parameter logic [N_REGION-1:0] PROG_MASK = '0,
  parameter logic [N_REGION-1:0] RESET_PRIV = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic awPrivBit,
  input  logic [ID_W-1:0] awId,
  input  ctrlStrobes_t strobes,
  output logic blocked,
  output logic [ID_W-1:0] errId,
  input  logic cfgWrEn,
  input  logic [1:0] cfgWrAddr,
  input  logic [N_REGION-1:0] cfgWrData,
  input  logic [1:0] cfgRdAddr,
  output logic [ADDR_W-1:0] cfgRdData
);
  localparam int IDX_W = (N_REGION > 1) ? $clog2(N_REGION) : 1;

  logic [N_REGION-1:0] privState;
  logic [N_REGION-1:0] privNext;
  logic [N_REGION-1:0] regionHit;
  logic [IDX_W-1:0] hitIdx;
  logic hitAny;
  logic violFlag;
  logic [ADDR_W-1:0] violAddr;
  logic privWrite;
  logic clrReq;

  assign privWrite = cfgWrEn && (cfgWrAddr == CFG_REG_PRIV);
  assign clrReq = cfgWrEn && (cfgWrAddr == CFG_REG_STAT) && cfgWrData[0];

  for (genvar g = 0; g < N_REGION; g++) begin : g_region
    assign regionHit[g] =
      ((awAddr & REGION_MASK[g*ADDR_W +: ADDR_W]) == REGION_BASE[g*ADDR_W +: ADDR_W]);
    // locked regions always reload their build-time value
    assign privNext[g] = PROG_MASK[g] ? cfgWrData[g] : RESET_PRIV[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) privState <= RESET_PRIV;
    else if (privWrite) privState <= privNext;
  end

  // lowest matching index wins
  always_comb begin
    hitAny = |regionHit;
    hitIdx = '0;
    for (int i = N_REGION - 1; i >= 0; i--) begin
      if (regionHit[i]) hitIdx = IDX_W'(i);
    end
    blocked = hitAny && privState[hitIdx] && !awPrivBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      violAddr <= '0;
      errId <= '0;
    end else begin
      if (clrReq) violFlag <= 1'b0;
      if (strobes.captureBlk) begin
        errId <= awId;
        if (!violFlag) begin
          violFlag <= 1'b1;
          violAddr <= awAddr;
        end
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    case (cfgRdAddr)
      CFG_REG_PRIV: cfgRdData[N_REGION-1:0] = privState;
      CFG_REG_STAT: cfgRdData[0] = violFlag;
      CFG_REG_ADDR: cfgRdData = violAddr;
      default: cfgRdData = '0;
    endcase
  end

  // R9: once set and not cleared, flag and captured address hold
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && !clrReq) |=> (violFlag && $stable(violAddr)));

  // R8: locked bits never leave their build-time value after a config write
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    privWrite |=> ((privState & ~PROG_MASK) == (RESET_PRIV & ~PROG_MASK)));
endmodule

// File: rtl/pwg_write_ctrl.sv
module pwg_write_ctrl
  import pwg_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sAwValid,
  output logic sAwReady,
  output logic mAwValid,
  input  logic mAwReady,
  input  logic blocked,
  input  logic sWValid,
  output logic sWReady,
  input  logic sWLast,
  output logic mWValid,
  input  logic mWReady,
  output logic sBValid,
  input  logic sBReady,
  output logic [1:0] sBResp,
  output logic [ID_W-1:0] sBId,
  input  logic mBValid,
  output logic mBReady,
  input  logic [1:0] mBResp,
  input  logic [ID_W-1:0] mBId,
  input  logic [ID_W-1:0] errId,
  output ctrlStrobes_t strobes
);
  wrState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE_S;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    sAwReady = 1'b0;
    mAwValid = 1'b0;
    sWReady = 1'b0;
    mWValid = 1'b0;
    strobes = '0;
    case (state)
      IDLE_S: begin
        mAwValid = sAwValid && !blocked;
        sAwReady = blocked ? 1'b1 : mAwReady;
        strobes.captureBlk = sAwValid && blocked;
        if (sAwValid && sAwReady) stateNext = blocked ? DRAIN_S : FWD_S;
      end
      FWD_S: begin
        mWValid = sWValid;
        sWReady = mWReady;
        if (sWValid && mWReady && sWLast) stateNext = IDLE_S;
      end
      DRAIN_S: begin
        sWReady = 1'b1;
        if (sWValid && sWLast) stateNext = RESP_S;
      end
      RESP_S: begin
        if (sBReady) stateNext = IDLE_S;
      end
      default: stateNext = IDLE_S;
    endcase
  end

  // response mux: local error while in RESP_S, target otherwise
  always_comb begin
    if (state == RESP_S) begin
      sBValid = 1'b1;
      sBResp = RESP_SLVERR;
      sBId = errId;
      mBReady = 1'b0;
    end else begin
      sBValid = mBValid;
      sBResp = mBResp;
      sBId = mBId;
      mBReady = sBReady;
    end
  end

  // R4: a blocked address never reaches the target
  p_blk_no_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sAwValid && blocked) |-> !mAwValid);

  // R4: drained beats are never shown to the target
  p_drain_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == DRAIN_S) |-> (sWReady && !mWValid));

  // R4: a pending error response holds its code and ID
  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == RESP_S && !sBReady) |=> (sBValid && sBResp == RESP_SLVERR && $stable(sBId)));

  // R10: no new address while a blocked write is open
  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == DRAIN_S) || (state == RESP_S && !sBReady)) |=> !sAwReady);
endmodule

// File: rtl/priv_write_guard.sv
module priv_write_guard
  import pwg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W = 4,
  parameter int N_REGION = 4,
  parameter logic [N_REGION*ADDR_W-1:0] REGION_BASE =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [N_REGION*ADDR_W-1:0] REGION_MASK = {N_REGION{32'hF000_0000}},
  parameter logic [N_REGION-1:0] PROG_MASK = 4'b0011,
  parameter logic [N_REGION-1:0] RESET_PRIV = 4'b0101
) (
  input  logic clk,
  input  logic rstN,
  input  logic sAwValid,
  output logic sAwReady,
  input  logic [ID_W-1:0] sAwId,
  input  logic [ADDR_W-1:0] sAwAddr,
  input  logic [2:0] sAwProt,
  input  logic sWValid,
  output logic sWReady,
  input  logic [DATA_W-1:0] sWData,
  input  logic [DATA_W/8-1:0] sWStrb,
  input  logic sWLast,
  output logic sBValid,
  input  logic sBReady,
  output logic [ID_W-1:0] sBId,
  output logic [1:0] sBResp,
  input  logic sArValid,
  output logic sArReady,
  input  logic [ID_W-1:0] sArId,
  input  logic [ADDR_W-1:0] sArAddr,
  input  logic [2:0] sArProt,
  output logic sRValid,
  input  logic sRReady,
  output logic [ID_W-1:0] sRId,
  output logic [DATA_W-1:0] sRData,
  output logic [1:0] sRResp,
  output logic sRLast,
  output logic mAwValid,
  input  logic mAwReady,
  output logic [ID_W-1:0] mAwId,
  output logic [ADDR_W-1:0] mAwAddr,
  output logic [2:0] mAwProt,
  output logic mWValid,
  input  logic mWReady,
  output logic [DATA_W-1:0] mWData,
  output logic [DATA_W/8-1:0] mWStrb,
  output logic mWLast,
  input  logic mBValid,
  output logic mBReady,
  input  logic [ID_W-1:0] mBId,
  input  logic [1:0] mBResp,
  output logic mArValid,
  input  logic mArReady,
  output logic [ID_W-1:0] mArId,
  output logic [ADDR_W-1:0] mArAddr,
  output logic [2:0] mArProt,
  input  logic mRValid,
  output logic mRReady,
  input  logic [ID_W-1:0] mRId,
  input  logic [DATA_W-1:0] mRData,
  input  logic [1:0] mRResp,
  input  logic mRLast,
  input  logic cfgWrEn,
  input  logic [1:0] cfgWrAddr,
  input  logic [N_REGION-1:0] cfgWrData,
  input  logic [1:0] cfgRdAddr,
  output logic [ADDR_W-1:0] cfgRdData
);
  logic blocked;
  logic [ID_W-1:0] errId;
  ctrlStrobes_t strobes;

  // reads are never checked
  assign mArValid = sArValid;
  assign sArReady = mArReady;
  assign mArId = sArId;
  assign mArAddr = sArAddr;
  assign mArProt = sArProt;
  assign sRValid = mRValid;
  assign mRReady = sRReady;
  assign sRId = mRId;
  assign sRData = mRData;
  assign sRResp = mRResp;
  assign sRLast = mRLast;

  // write payload rides along; only the valids are gated
  assign mAwId = sAwId;
  assign mAwAddr = sAwAddr;
  assign mAwProt = sAwProt;
  assign mWData = sWData;
  assign mWStrb = sWStrb;
  assign mWLast = sWLast;

  pwg_region_path #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .N_REGION(N_REGION),
    .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK),
    .PROG_MASK(PROG_MASK), .RESET_PRIV(RESET_PRIV)
  ) path_i (
    .clk(clk), .rstN(rstN),
    .awAddr(sAwAddr), .awPrivBit(sAwProt[0]), .awId(sAwId),
    .strobes(strobes), .blocked(blocked), .errId(errId),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData)
  );

  pwg_write_ctrl #(.ID_W(ID_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .sAwValid(sAwValid), .sAwReady(sAwReady),
    .mAwValid(mAwValid), .mAwReady(mAwReady),
    .blocked(blocked),
    .sWValid(sWValid), .sWReady(sWReady), .sWLast(sWLast),
    .mWValid(mWValid), .mWReady(mWReady),
    .sBValid(sBValid), .sBReady(sBReady), .sBResp(sBResp), .sBId(sBId),
    .mBValid(mBValid), .mBReady(mBReady), .mBResp(mBResp), .mBId(mBId),
    .errId(errId), .strobes(strobes)
  );
endmodule

// File: tb/priv_write_guard_tb_top.sv
`timescale 1ns/1ps
module priv_write_guard_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ID_W = 4;
  localparam int NR = 4;
  localparam logic [NR-1:0] PROG = 4'b0011;
  localparam logic [NR-1:0] RST = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic sAwValid, sAwReady; logic [ID_W-1:0] sAwId; logic [ADDR_W-1:0] sAwAddr; logic [2:0] sAwProt;
  logic sWValid, sWReady; logic [DATA_W-1:0] sWData; logic [DATA_W/8-1:0] sWStrb; logic sWLast;
  logic sBValid, sBReady; logic [ID_W-1:0] sBId; logic [1:0] sBResp;
  logic sArValid, sArReady; logic [ID_W-1:0] sArId; logic [ADDR_W-1:0] sArAddr; logic [2:0] sArProt;
  logic sRValid, sRReady; logic [ID_W-1:0] sRId; logic [DATA_W-1:0] sRData; logic [1:0] sRResp; logic sRLast;
  logic mAwValid, mAwReady; logic [ID_W-1:0] mAwId; logic [ADDR_W-1:0] mAwAddr; logic [2:0] mAwProt;
  logic mWValid, mWReady; logic [DATA_W-1:0] mWData; logic [DATA_W/8-1:0] mWStrb; logic mWLast;
  logic mBValid, mBReady; logic [ID_W-1:0] mBId; logic [1:0] mBResp;
  logic mArValid, mArReady; logic [ID_W-1:0] mArId; logic [ADDR_W-1:0] mArAddr; logic [2:0] mArProt;
  logic mRValid, mRReady; logic [ID_W-1:0] mRId; logic [DATA_W-1:0] mRData; logic [1:0] mRResp; logic mRLast;
  logic cfgWrEn; logic [1:0] cfgWrAddr; logic [NR-1:0] cfgWrData; logic [1:0] cfgRdAddr; logic [ADDR_W-1:0] cfgRdData;

  priv_write_guard dut_i (.*);

  int nVec = 0;
  int nBad = 0;
  logic [NR-1:0] expPriv;
  bit expFlag;
  logic [ADDR_W-1:0] expAddr;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit isBlocked(input logic [ADDR_W-1:0] a, input logic [2:0] p);
    int rg = int'(a[31:28]);
    return (rg < NR) && expPriv[rg] && !p[0];
  endfunction

  function automatic logic [DATA_W-1:0] beatData(input logic [ID_W-1:0] id, input int beat);
    return 32'hA500_0000 | (32'(id) << 8) | 32'(beat);
  endfunction

  task automatic cfgWr(input logic [1:0] a, input logic [NR-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 2'd0) expPriv = (d & PROG) | (RST & ~PROG);
    if (a == 2'd1 && d[0]) expFlag = 1'b0;
  endtask

  task automatic cfgRd(input logic [1:0] a, output logic [ADDR_W-1:0] d);
    cfgRdAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic chkStat(input string tag);
    logic [ADDR_W-1:0] d;
    cfgRd(2'd0, d); chk({tag, " privilege vector"}, d, {28'd0, expPriv});
    cfgRd(2'd1, d); chk({tag, " sticky flag"}, d, {31'd0, expFlag});
    cfgRd(2'd2, d); chk({tag, " captured address"}, d, expAddr);
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] addr, input logic [2:0] prot,
                         input logic [ID_W-1:0] id, input int beats, input string tag);
    bit blk = isBlocked(addr, prot);
    bit awDone = 0, bPend = 0, done = 0, leak = 0;
    int wSent = 0, mAwSeen = 0, mWSeen = 0;
    while (!done) begin
      @(negedge clk);
      sAwValid = !awDone; sAwAddr = addr; sAwProt = prot; sAwId = id;
      sWValid = (wSent < beats); sWData = beatData(id, wSent);
      sWLast = (wSent == beats - 1); sWStrb = '1;
      mAwReady = 1'($urandom % 2); mWReady = 1'($urandom % 2); sBReady = 1'($urandom % 2);
      mBValid = bPend; mBId = id; mBResp = 2'b00;
      #1;
      if (awDone && blk) chk("R10 address ready while blocked write open", sAwReady, 1'b0);
      if (blk && (mAwValid || mWValid)) leak = 1;
      if (mAwValid && mAwReady) begin
        mAwSeen++;
        chk({tag, " fwd addr"}, mAwAddr, addr);
        chk({tag, " fwd id"}, mAwId, id);
        chk({tag, " fwd prot"}, mAwProt, prot);
      end
      if (mWValid && mWReady) begin
        chk({tag, " fwd data"}, mWData, beatData(id, mWSeen));
        chk({tag, " fwd last"}, mWLast, (mWSeen == beats - 1));
        mWSeen++;
        if (mWLast) bPend = 1;
      end
      if (sAwValid && sAwReady) awDone = 1;
      if (sWValid && sWReady) wSent++;
      if (mBValid && mBReady) bPend = 0;
      if (sBValid && sBReady) begin
        chk({tag, " bresp"}, sBResp, blk ? 2'b10 : 2'b00);
        chk({tag, " bid"}, sBId, id);
        done = 1;
      end
    end
    @(negedge clk);
    sAwValid = 0; sWValid = 0; mBValid = 0; sBReady = 0; mAwReady = 0; mWReady = 0;
    chk({tag, " target address count"}, mAwSeen, blk ? 0 : 1);
    chk({tag, " target beat count"}, mWSeen, blk ? 0 : beats);
    chk({tag, " beats accepted"}, wSent, beats);
    if (blk) chk("R4 no valid toward target", leak, 0);
    if (blk && !expFlag) begin expFlag = 1; expAddr = addr; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R4 watchdog act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] d;
    void'($urandom(32'd7));
    sAwValid = 0; sAwId = 0; sAwAddr = 0; sAwProt = 0;
    sWValid = 0; sWData = 0; sWStrb = 0; sWLast = 0; sBReady = 0;
    sArValid = 0; sArId = 0; sArAddr = 0; sArProt = 0; sRReady = 0;
    mAwReady = 0; mWReady = 0; mBValid = 0; mBId = 0; mBResp = 0;
    mArReady = 0; mRValid = 0; mRId = 0; mRData = 0; mRResp = 0; mRLast = 0;
    cfgWrEn = 0; cfgWrAddr = 0; cfgWrData = 0; cfgRdAddr = 0;
    expPriv = RST; expFlag = 0; expAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state
    chkStat("R6 reset");
    chk("R6 no response after reset", sBValid, 1'b0);
    chk("R6 no target address after reset", mAwValid, 1'b0);

    // directed corners
    doWrite(32'h0000_0010, 3'b001, 4'd1, 2, "R2");
    doWrite(32'h1000_0020, 3'b000, 4'd2, 1, "R3");
    doWrite(32'h3000_0040, 3'b001, 4'd3, 3, "R3");
    doWrite(32'h0000_0100, 3'b000, 4'd4, 3, "R4");
    chkStat("R9 first capture");
    doWrite(32'h2000_0200, 3'b110, 4'd5, 4, "R4");
    chkStat("R9 second blocked keeps first");
    doWrite(32'h5000_0000, 3'b000, 4'd6, 2, "R5");
    doWrite(32'hF000_0008, 3'b000, 4'd7, 1, "R5");
    cfgWr(2'd1, 4'b0001);
    chkStat("R9 cleared");

    cfgWr(2'd0, 4'b1010);
    chkStat("R7 R8 reprogram");
    doWrite(32'h0000_0300, 3'b000, 4'd8, 1, "R7");
    doWrite(32'h1000_0300, 3'b000, 4'd9, 2, "R7");
    doWrite(32'h2000_0300, 3'b000, 4'd10, 1, "R8");
    doWrite(32'h3000_0300, 3'b000, 4'd11, 1, "R8");
    chkStat("R9 recapture");

    // reads pass through even where a write would be blocked
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sArValid = 1'($urandom % 2); sArAddr = (k % 2 == 0) ? 32'h2000_0000 + 32'(k) : $urandom;
      sArProt = 3'($urandom); sArId = 4'($urandom); mArReady = 1'($urandom % 2);
      mRValid = 1'($urandom % 2); mRData = $urandom; mRResp = 2'($urandom);
      mRId = 4'($urandom); mRLast = 1'($urandom % 2); sRReady = 1'($urandom % 2);
      #1;
      chk("R1 arvalid", mArValid, sArValid);
      chk("R1 araddr", mArAddr, sArAddr);
      chk("R1 arprot", mArProt, sArProt);
      chk("R1 arid", mArId, sArId);
      chk("R1 arready", sArReady, mArReady);
      chk("R1 rvalid", sRValid, mRValid);
      chk("R1 rdata", sRData, mRData);
      chk("R1 rresp", sRResp, mRResp);
      chk("R1 rid", sRId, mRId);
      chk("R1 rlast", sRLast, mRLast);
      chk("R1 rready", mRReady, sRReady);
    end
    @(negedge clk);
    sArValid = 0; mRValid = 0;

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [ADDR_W-1:0] a;
      logic [2:0] p;
      if (n % 8 == 0) cfgWr(2'd0, 4'($urandom));
      if (n % 13 == 5) cfgWr(2'd1, 4'b0001);
      a = {4'($urandom % 6), 28'($urandom) & 28'hFFF_FFFC};
      p = 3'($urandom);
      doWrite(a, p, 4'($urandom), 1 + int'($urandom % 4), isBlocked(a, p) ? "R4" : "R3");
      if (n % 10 == 9) chkStat("R9 random");
    end
    chkStat("R9 final");

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule